// File: doc/BRIEF.md
# Bus Master Cycle Controller with Exception Handling

This block runs single read or write transfers on an asynchronous 16-bit data bus for an on-chip requester. The requester hands over an address, a function code, byte enables, a direction and write data through a valid/ready pair. The block asks for the bus, waits for the grant, and then steps the transfer through address, strobe, wait and delay phases. It inserts wait states until the slave acknowledges, and for every transfer that finishes it sends one response pulse carrying a status and the read data.

While a transfer is open, a 3-bit active-low exception code from the bus side can change how it ends. One code completes the transfer and then halts. Others end it with a bus error, rerun it while holding the bus, or rerun it after giving the bus up and winning arbitration again. Two codes are reserved and end the transfer as an error after one extra clock. The all-low code resets the controller.

The timing of the code against the acknowledge matters. A code seen before the acknowledge acts at once. A code seen together with the acknowledge, or one clock after it, is caught by a single delay state that always follows an acknowledge. After any exceptional ending, no transfer starts until the code is all high again. Both the acknowledge and the code pass through two synchronizing flops before the controller uses them.

Top module: `bmc_bus_master`

## Requirements
- R1: While reset is held, and after it is released, `as_n` and both `ds_n` bits are high, `bus_oe`, `dat_oe`, `bus_req` and `rsp_valid` are low, and `req_ready` is high once idle.
- R2: An accepted request raises `bus_req`. After `bus_grant`, address, function code and `rw_o` (1 = read, 0 = write) are driven with `bus_oe` high before `as_n` falls. The data strobes are low only while `as_n` is low. `dat_oe` is high, with `dat_o` equal to the write data, only for writes.
- R3: `req_be[1]` selects `ds_n[1]` (upper byte) and `req_be[0]` selects `ds_n[0]`. A transfer that ends with the code at 111 gives exactly one `rsp_valid` pulse with status 0 (done) and, for reads, the bus data.
- R4: While `dtack_n` stays high and the code is 111, the strobes stay asserted and no response is given.
- R5: Code 2 (`bec_n`=101) seen before the acknowledge ends the transfer at once with status 1 (bus error). AS and the strobes go high and every output enable drops in the same clock.
- R6: Code 3 (`bec_n`=100) ends the strobes with no response. `bus_req`, `bus_oe` and the address are held while the code stays present, and the same transfer is rerun when the code returns to 111.
- R7: Code 4 (`bec_n`=011) ends the transfer with no response, drops `bus_req` and `bus_oe`, and reruns the same transfer after a new grant once the code returns to 111.
- R8: Code 1 (`bec_n`=110) lets the transfer run until the acknowledge, then gives status 2 (halted) with the read data and releases the bus.
- R9: After an exceptional ending, `req_ready` stays low until the code is 111 again.
- R10: A code that arrives one clock after the acknowledge is still acted on: code 2 then gives status 1.
- R11: Reserved codes 5 and 6 (`bec_n`=010, 001) add one clock and then end the transfer with status 1, followed by the same wait for 111.
- R12: Code 7 (`bec_n`=000) resets the controller: the bus is released, `bus_req` drops, no response is given, and requests are taken again after the code returns to 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request taken on this clock |
| req_addr | input | 31 | Word address (bus address bits 31..1) |
| req_fc | input | 4 | Function code |
| req_be | input | 2 | Byte enables, bit 1 upper |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_status | output | 2 | 0 done, 1 bus error, 2 halted |
| rsp_rdata | output | 16 | Read data |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| adr_o | output | 31 | Bus address |
| fc_o | output | 4 | Bus function code |
| rw_o | output | 1 | Direction, high for read |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 2 | Data strobes, bit 1 upper, active low |
| dat_o | output | 16 | Bus write data |
| dat_oe | output | 1 | Output enable for `dat_o` |
| bus_oe | output | 1 | Output enable for address, function code, direction and strobes |
| dat_i | input | 16 | Bus read data |
| dtack_n | input | 1 | Transfer acknowledge, active low |
| bec_n | input | 3 | Exception code, active low |

## Verification
A wrong state in the controller shows up at the bus pins within the clock after the synchronized input reaches it. A missed exception leaves `as_n` low, an early release drops `bus_oe`, and a lost hold lets `req_ready` rise while the code is still set. A retry or relinquish that latched the wrong fields is caught at the second falling edge of `as_n`, where the address must equal the first one. A response with the wrong status or data is caught when it is compared against the queued expectation, which happens two to four clocks after the acknowledge or code is applied.

// File: rtl/bmc_pkg.sv
// Shared types for the bus master cycle controller.
// Assumes a 3-bit exception code that has already been inverted to active high.
package bmc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_S0,
        ST_S2,
        ST_S4,
        ST_SW,
        ST_S6,
        ST_HOLD
    } bmc_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_HALT,
        K_BERR,
        K_RETRY,
        K_RELQ
    } exc_kind_e;

    typedef enum logic [1:0] {
        RS_DONE = 2'd0,
        RS_BERR = 2'd1,
        RS_HALT = 2'd2
    } rsp_status_e;

endpackage

// File: rtl/bmc_sync.sv
// Two-flop synchronizer for asynchronous bus inputs.
// Assumes the inputs idle high, so the flops reset to all ones.
module bmc_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // capture then re-register the asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '1;
            q    <= '1;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/bmc_exc_decode.sv
// Classifies the synchronized, active-high exception code.
// Assumes the caller decides when each class is acted upon.
module bmc_exc_decode
    import bmc_pkg::*;
#(
    parameter int EW = 3
) (
    input  logic [EW-1:0] code,
    output exc_kind_e     outcome,
    output logic          cut_now,
    output logic          delay_only,
    output logic          soft_reset
);
    // map each code to its outcome and its timing class
    always_comb begin
        outcome    = K_NONE;
        cut_now    = 1'b0;
        delay_only = 1'b0;
        soft_reset = 1'b0;
        unique case (code)
            3'd1: outcome = K_HALT;
            3'd2: begin outcome = K_BERR;  cut_now = 1'b1; end
            3'd3: begin outcome = K_RETRY; cut_now = 1'b1; end
            3'd4: begin outcome = K_RELQ;  cut_now = 1'b1; end
            3'd5, 3'd6: begin outcome = K_BERR; delay_only = 1'b1; end
            3'd7: soft_reset = 1'b1;
            default: outcome = K_NONE;
        endcase
    end
endmodule

// File: rtl/bmc_bus_master.sv
// Bus master cycle controller: runs one read or write transfer per request on
// an asynchronous bus, with wait states and exception-code handling.
// Assumes bus_grant is synchronous to clk and that pads are tri-stated
// outside through bus_oe and dat_oe.
module bmc_bus_master
    import bmc_pkg::*;
#(
    parameter int AW = 31,
    parameter int DW = 16,
    parameter int FW = 4,
    parameter int EW = 3,
    localparam int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [FW-1:0] req_fc,
    input  logic [BW-1:0] req_be,
    input  logic          req_wr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [1:0]    rsp_status,
    output logic [DW-1:0] rsp_rdata,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic [AW-1:0] adr_o,
    output logic [FW-1:0] fc_o,
    output logic          rw_o,
    output logic          as_n,
    output logic [BW-1:0] ds_n,
    output logic [DW-1:0] dat_o,
    output logic          dat_oe,
    output logic          bus_oe,
    input  logic [DW-1:0] dat_i,
    input  logic          dtack_n,
    input  logic [EW-1:0] bec_n
);
    localparam int SW_W = EW + 1;

    logic [SW_W-1:0] raw_s;
    logic            dk_s;
    logic [EW-1:0]   ex_s;
    exc_kind_e       outcome;
    logic            cut_now, delay_only, soft_reset, ctl_rst;

    bmc_state_e      st;
    exc_kind_e       hk;
    logic [AW-1:0]   adr_r;
    logic [FW-1:0]   fc_r;
    logic [BW-1:0]   be_r;
    logic            wr_r;
    logic [DW-1:0]   wd_r, rd_r;
    rsp_status_e     rs_r;

    bmc_state_e      fin_st;
    logic            fin_rsp;
    rsp_status_e     fin_status;
    logic            drive, in_as, strobe_on;

    bmc_sync #(.W(SW_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dtack_n, bec_n}),
        .q     (raw_s)
    );

    assign dk_s = ~raw_s[EW];
    assign ex_s = ~raw_s[EW-1:0];

    bmc_exc_decode #(.EW(EW)) u_dec (
        .code       (ex_s),
        .outcome    (outcome),
        .cut_now    (cut_now),
        .delay_only (delay_only),
        .soft_reset (soft_reset)
    );

    assign ctl_rst   = !rst_n || soft_reset;
    assign req_ready = (st == ST_IDLE) && (ex_s == '0);

    // where a transfer goes when it ends with the current outcome
    always_comb begin
        fin_st     = ST_HOLD;
        fin_rsp    = 1'b1;
        fin_status = RS_BERR;
        unique case (outcome)
            K_NONE:  begin fin_st = ST_IDLE; fin_status = RS_DONE; end
            K_HALT:  fin_status = RS_HALT;
            K_RETRY, K_RELQ: fin_rsp = 1'b0;
            default: fin_status = RS_BERR;
        endcase
    end

    // transfer sequencer, request latch and response register
    always_ff @(posedge clk) begin
        if (ctl_rst) begin
            st        <= ST_IDLE;
            hk        <= K_NONE;
            rsp_valid <= 1'b0;
            rs_r      <= RS_DONE;
            rd_r      <= '0;
            adr_r     <= '0;
            fc_r      <= '0;
            be_r      <= '0;
            wr_r      <= 1'b0;
            wd_r      <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (st)
                ST_IDLE: if (req_valid && req_ready) begin
                    adr_r <= req_addr;
                    fc_r  <= req_fc;
                    be_r  <= req_be;
                    wr_r  <= req_wr;
                    wd_r  <= req_wdata;
                    st    <= ST_ARB;
                end
                ST_ARB: if (bus_grant) st <= ST_S0;
                ST_S0:  st <= ST_S2;
                ST_S2:  st <= ST_S4;
                ST_S4:  st <= ST_SW;
                ST_SW: begin
                    if (cut_now) begin
                        st        <= fin_st;
                        hk        <= outcome;
                        rsp_valid <= fin_rsp;
                        rs_r      <= fin_status;
                    end else if (dk_s || delay_only) begin
                        st <= ST_S6;
                    end
                end
                ST_S6: begin
                    rd_r      <= dat_i;
                    st        <= fin_st;
                    hk        <= outcome;
                    rsp_valid <= fin_rsp;
                    rs_r      <= fin_status;
                end
                ST_HOLD: if (ex_s == '0) begin
                    st <= (hk == K_RETRY) ? ST_S0 :
                          (hk == K_RELQ)  ? ST_ARB : ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // bus pin decode from the sequencer state
    always_comb begin
        drive     = (st inside {ST_S0, ST_S2, ST_S4, ST_SW, ST_S6}) ||
                    (st == ST_HOLD && hk == K_RETRY);
        in_as     = st inside {ST_S2, ST_S4, ST_SW, ST_S6};
        strobe_on = (st inside {ST_S4, ST_SW, ST_S6}) || (st == ST_S2 && !wr_r);
        bus_oe    = drive;
        dat_oe    = drive && wr_r;
        bus_req   = drive || (st == ST_ARB);
        as_n      = !in_as;
        ds_n      = strobe_on ? ~be_r : '1;
        adr_o     = adr_r;
        fc_o      = fc_r;
        rw_o      = !wr_r;
        dat_o     = wd_r;
    end

    assign rsp_status = rs_r;
    assign rsp_rdata  = rd_r;

    // R2: data strobes only inside an address strobe
    p_ds_in_as_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_n != '1) |-> !as_n);

    // R3: a response is a single-clock pulse
    p_one_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R4: no acknowledge and no exception keeps the strobes asserted
    p_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SW && !dk_s && (ex_s == '0 || ex_s == 3'd1)) |=> !as_n);

    // R5: a released bus has every strobe high and no data drive
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (as_n && ds_n == '1 && !dat_oe));

    // R6: a retry hold keeps the address and the bus request
    p_retry_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && hk == K_RETRY && ex_s != 3'd7) |=> ($stable(adr_o) && bus_req));

    // R9: no transfer starts while a code is present
    p_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && ex_s != '0) |=> st != ST_ARB);

    // R12: the all-low code returns the controller to idle without a response
    p_soft_rst_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_s == 3'd7) |=> (st == ST_IDLE && !rsp_valid && !bus_req));
endmodule

// File: tb/bmc_bus_master_tb.sv
module bmc_bus_master_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, req_wr = 0;
    logic        req_ready;
    logic [30:0] req_addr = '0;
    logic [3:0]  req_fc = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [15:0] rsp_rdata;
    logic        bus_req, bus_grant = 0;
    logic [30:0] adr_o;
    logic [3:0]  fc_o;
    logic        rw_o, as_n, dat_oe, bus_oe;
    logic [1:0]  ds_n;
    logic [15:0] dat_o, dat_i = '0;
    logic        dtack_n = 1;
    logic [2:0]  bec_n = 3'b111;

    bmc_bus_master u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_fc(req_fc), .req_be(req_be), .req_wr(req_wr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_rdata(rsp_rdata), .bus_req(bus_req), .bus_grant(bus_grant),
        .adr_o(adr_o), .fc_o(fc_o), .rw_o(rw_o), .as_n(as_n), .ds_n(ds_n),
        .dat_o(dat_o), .dat_oe(dat_oe), .bus_oe(bus_oe), .dat_i(dat_i),
        .dtack_n(dtack_n), .bec_n(bec_n)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0, cycles = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard queue of expected responses
    typedef struct { logic [1:0] st; logic [15:0] d; bit use_d; string tag; } exp_t;
    exp_t q[$];
    int rsp_cnt = 0;

    task automatic push_exp(input logic [1:0] s, input logic [15:0] d, input bit ud, input string tag);
        exp_t e;
        e.st = s; e.d = d; e.use_d = ud; e.tag = tag;
        q.push_back(e);
    endtask

    // arbiter model: grant follows request after two clocks
    logic g1 = 0;
    always @(negedge clk) begin
        bus_grant = g1 && bus_req;
        g1 = bus_req;
    end

    // slave model with exception injection
    int dly = 3, mode = 0, cnt = 0;
    logic [2:0]  inj = 0;
    logic [15:0] rd_val = 0;
    bit armed = 0, pend = 0;
    always @(negedge clk) begin
        if (as_n) begin
            cnt = 0;
            dtack_n = 1;
        end else if (ds_n != 2'b11) begin
            cnt++;
            if (pend) begin
                bec_n = ~inj; armed = 0; pend = 0;
            end
            if (armed && mode == 1 && cnt == 2) begin
                bec_n = ~inj; armed = 0;
            end
            if (cnt == dly && dtack_n) begin
                dtack_n = 0;
                dat_i = rd_val;
                if (armed && mode == 2) begin bec_n = ~inj; armed = 0; end
                else if (armed && mode == 3) pend = 1;
            end
        end
    end

    // bus monitor: records what was driven at each strobe edge
    logic prev_as = 1;
    logic [1:0] prev_ds = 2'b11;
    int as_cnt = 0;
    logic [30:0] m_adr; logic [3:0] m_fc; logic m_rw, m_oe, m_doe;
    logic [1:0] m_ds; logic [15:0] m_dat;
    always @(negedge clk) begin
        if (prev_as && !as_n) begin
            as_cnt++; m_adr = adr_o; m_fc = fc_o; m_rw = rw_o; m_oe = bus_oe;
        end
        if (prev_ds == 2'b11 && ds_n != 2'b11) begin
            m_ds = ds_n; m_doe = dat_oe; m_dat = dat_o;
        end
        prev_as = as_n; prev_ds = ds_n;
    end

    // response monitor: pops and compares
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            rsp_cnt++;
            if (q.size() == 0) chk(0, "R3 unexpected response", rsp_status, 0);
            else begin
                exp_t e;
                e = q.pop_front();
                chk(rsp_status == e.st, {e.tag, " status"}, rsp_status, e.st);
                if (e.use_d) chk(rsp_rdata == e.d, {e.tag, " rdata"}, rsp_rdata, e.d);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic issue(input logic [30:0] a, input logic [3:0] f, input logic [1:0] b,
                         input logic w, input logic [15:0] d);
        @(negedge clk);
        req_addr = a; req_fc = f; req_be = b; req_wr = w; req_wdata = d; req_valid = 1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_rsp(input int n);
        while (rsp_cnt < n) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic setup(input int m, input logic [2:0] c, input int d, input logic [15:0] rv);
        mode = m; inj = c; dly = d; rd_val = rv; armed = (m != 0); pend = 0;
    endtask

    task automatic wait_inject();
        while (bec_n == 3'b111) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic clear_code();
        bec_n = 3'b111;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int n, a0;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(as_n && ds_n == 2'b11 && !bus_oe && !dat_oe && !bus_req && !rsp_valid,
            "R1 reset outputs", {as_n, ds_n, bus_oe, dat_oe, bus_req}, 6'b111000);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(req_ready && as_n && !bus_oe, "R1 idle ready", req_ready, 1);

        // R2 R3: plain write, both bytes
        setup(0, 0, 3, 0);
        push_exp(0, 0, 0, "R3 write done");
        n = rsp_cnt; a0 = as_cnt;
        issue(31'h0012_3456, 4'h5, 2'b11, 1, 16'hA5C3);
        wait_rsp(n + 1);
        chk(as_cnt == a0 + 1, "R2 one address strobe", as_cnt - a0, 1);
        chk(m_adr == 31'h0012_3456 && m_fc == 4'h5 && m_rw == 0 && m_oe,
            "R2 write address phase", m_adr, 31'h0012_3456);
        chk(m_ds == 2'b00 && m_doe && m_dat == 16'hA5C3, "R2 write data drive", m_dat, 16'hA5C3);
        chk(!bus_oe && !bus_req, "R2 bus released after done", bus_oe, 0);

        // R3: upper byte read
        setup(0, 0, 3, 16'hBEEF);
        push_exp(0, 16'hBEEF, 1, "R3 read done");
        n = rsp_cnt;
        issue(31'h0000_0100, 4'h1, 2'b10, 0, 0);
        wait_rsp(n + 1);
        chk(m_ds == 2'b01 && m_rw == 1 && !m_doe, "R3 upper strobe read", m_ds, 2'b01);

        // R4: long wait states
        setup(0, 0, 14, 16'h0F0F);
        push_exp(0, 16'h0F0F, 1, "R4 read after wait");
        n = rsp_cnt;
        issue(31'h0000_0200, 4'h2, 2'b01, 0, 0);
        while (ds_n == 2'b11) @(negedge clk);
        repeat (8) @(negedge clk);
        chk(!as_n && ds_n == 2'b10 && rsp_cnt == n, "R4 strobes held in wait", ds_n, 2'b10);
        wait_rsp(n + 1);

        // R5 R9: early bus error
        setup(1, 3'd2, 20, 0);
        push_exp(1, 0, 0, "R5 early bus error");
        n = rsp_cnt;
        issue(31'h0000_0300, 4'h3, 2'b11, 0, 0);
        wait_rsp(n + 1);
        chk(!bus_oe && as_n && ds_n == 2'b11 && !dat_oe, "R5 bus released", bus_oe, 0);
        chk(!req_ready, "R9 held while code present", req_ready, 0);
        clear_code();
        chk(req_ready, "R9 ready after code clears", req_ready, 1);

        // R6: retry holding the bus
        setup(1, 3'd3, 20, 16'h1111);
        push_exp(0, 16'h1111, 1, "R6 retry completes");
        n = rsp_cnt; a0 = as_cnt;
        issue(31'h0000_0400, 4'h4, 2'b11, 0, 0);
        wait_inject();
        chk(bus_req && bus_oe && as_n && adr_o == 31'h0000_0400 && rsp_cnt == n,
            "R6 hold keeps bus", {bus_req, bus_oe, as_n}, 3'b111);
        clear_code();
        wait_rsp(n + 1);
        chk(as_cnt == a0 + 2 && m_adr == 31'h0000_0400, "R6 identical rerun", as_cnt - a0, 2);

        // R7: relinquish and retry
        setup(1, 3'd4, 20, 16'h2222);
        push_exp(0, 16'h2222, 1, "R7 relinquish completes");
        n = rsp_cnt; a0 = as_cnt;
        issue(31'h0000_0500, 4'h6, 2'b11, 0, 0);
        wait_inject();
        chk(!bus_req && !bus_oe && rsp_cnt == n, "R7 bus given up", {bus_req, bus_oe}, 0);
        clear_code();
        wait_rsp(n + 1);
        chk(as_cnt == a0 + 2 && m_adr == 31'h0000_0500, "R7 rerun after grant", as_cnt - a0, 2);

        // R8 R9: halt arriving with the acknowledge
        setup(2, 3'd1, 3, 16'h1357);
        push_exp(2, 16'h1357, 1, "R8 halted with data");
        n = rsp_cnt;
        issue(31'h0000_0600, 4'h7, 2'b11, 0, 0);
        wait_rsp(n + 1);
        chk(!bus_oe && !req_ready, "R8 released and R9 held", {bus_oe, req_ready}, 0);
        clear_code();

        // R10: bus error one clock after the acknowledge
        setup(3, 3'd2, 3, 16'h5555);
        push_exp(1, 0, 0, "R10 late bus error");
        n = rsp_cnt;
        issue(31'h0000_0700, 4'h8, 2'b11, 0, 0);
        wait_rsp(n + 1);
        clear_code();

        // R11: reserved codes
        setup(1, 3'd5, 20, 0);
        push_exp(1, 0, 0, "R11 reserved 5");
        n = rsp_cnt;
        issue(31'h0000_0800, 4'h9, 2'b11, 1, 16'h7777);
        wait_rsp(n + 1);
        chk(!req_ready && !bus_oe, "R11 hold after reserved", req_ready, 0);
        clear_code();
        setup(2, 3'd6, 3, 0);
        push_exp(1, 0, 0, "R11 reserved 6");
        n = rsp_cnt;
        issue(31'h0000_0900, 4'hA, 2'b01, 0, 0);
        wait_rsp(n + 1);
        clear_code();

        // R12: reset code mid-transfer
        setup(1, 3'd7, 20, 0);
        n = rsp_cnt;
        issue(31'h0000_0A00, 4'hB, 2'b11, 0, 0);
        wait_inject();
        chk(as_n && !bus_oe && !bus_req && rsp_cnt == n && !req_ready,
            "R12 controller reset", {as_n, bus_oe, bus_req}, 3'b100);
        clear_code();
        chk(req_ready, "R12 ready after reset code", req_ready, 1);
        setup(0, 0, 3, 0);
        push_exp(0, 0, 0, "R12 transfer after reset code");
        n = rsp_cnt;
        issue(31'h0000_0B00, 4'hC, 2'b11, 1, 16'h9999);
        wait_rsp(n + 1);
        chk(m_dat == 16'h9999 && m_adr == 31'h0000_0B00, "R12 fresh transfer", m_dat, 16'h9999);

        chk(q.size() == 0, "R3 all responses seen", q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule